// File: doc/BRIEF.md
# Four-Way Translation Look-Aside Buffer with Per-Set LRU

This block caches translations from virtual to physical page numbers for a 32-bit address space split into 4 KB pages. The caller supplies the 20-bit virtual page number. The lookup port answers in the same cycle with a hit flag, the 20-bit physical page number and four control bits. After a miss, the page walker outside the block writes the mapping in through the fill port. A flush input drops every mapping at once.

Storage holds 64 entries, arranged as 16 sets of 4 ways. The set is chosen by the four least significant virtual page number bits, so neighbouring pages map to different sets. The upper 16 bits form the tag. Each set keeps a full least-recently-used ranking of its four ways. A fill writes into an empty way when the set has one. Otherwise the fill replaces the way that was used least recently.

Top module: `tlb_lru`

## Requirements
- R1: After synchronous reset no entry is valid, and every lookup misses until a fill is made.
- R2: With `lk_en` high, `lk_hit` rises in the same cycle when a valid way of set `lk_vpn[3:0]` holds tag `lk_vpn[19:4]`. On a hit, `lk_ppn` and `lk_ctrl` show that way's stored values. With `lk_en` low, or on a miss, `lk_hit`, `lk_ppn` and `lk_ctrl` are all zero.
- R3: Sixteen consecutive virtual page numbers fall into sixteen different sets and can all be resident together. Page numbers that share bits [3:0] but differ in bits [19:4] compete for the four ways of one set.
- R4: A fill presented in one cycle can be looked up from the next cycle onward. The lookup returns the filled physical page number and control bits.
- R5: When the target set has an empty way, a fill evicts no resident mapping.
- R6: When all four ways of the set are valid, a fill of a new page replaces the least recently used way.
- R7: A lookup with `lk_en` high that hits makes its way the most recently used in its set. A lookup with `lk_en` low leaves the order unchanged. A filled way also becomes the most recently used.
- R8: A fill whose page number is already resident overwrites that way in place and evicts nothing else.
- R9: A flush invalidates all 64 entries in one cycle. A fill presented in the same cycle as a flush is discarded.
- R10: When a hitting lookup and a fill address the same set in one cycle, only the fill updates that set's order. When they address different sets, both updates take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_en | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | 20 | Physical page number on hit |
| lk_ctrl | output | 4 | Control bits on hit |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_ppn | input | 20 | Physical page number being installed |
| fill_ctrl | input | 4 | Control bits being installed |

## Verification
A corrupted replacement ranking does not show at the ports right away. It shows only on the first fill into a full set after the corruption, when the wrong page is evicted. A lookup of a page that should still be resident then misses, or a page that should be gone still hits. For this reason the tests follow each ordering step with a forced eviction and then look up every affected page. A stale valid bit or tag shows on the very next lookup of that set, as a wrong hit flag or a wrong physical page number.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W    = 20;
    parameter int PPN_W    = 20;
    parameter int CTRL_W   = 4;
    parameter int WAYS     = 4;
    parameter int SET_BITS = 4;

    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = VPN_W - SET_BITS;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [SET_BITS-1:0] set_t;
    typedef logic [WAY_W-1:0]    way_t;

    typedef struct packed {
        logic              valid;
        tag_t              tag;
        logic [PPN_W-1:0]  ppn;
        logic [CTRL_W-1:0] ctrl;
    } entry_t;

    // age 0 = most recently used, WAYS-1 = least recently used
    typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

    function automatic ages_t ages_touch(ages_t a, way_t w);
        ages_t r;
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)  r[i] = '0;
            else if (a[i] < a[w]) r[i] = a[i] + 1'b1;
            else                  r[i] = a[i];
        end
        return r;
    endfunction

    function automatic ages_t ages_init();
        ages_t r;
        for (int i = 0; i < WAYS; i++) r[i] = way_t'(WAYS - 1 - i);
        return r;
    endfunction
endpackage

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  set_t   rd_set,
    input  set_t   fl_set,
    input  logic   wr_en,
    input  entry_t wr_entry,
    output entry_t rd_entry,
    output entry_t fl_entry
);
    entry_t mem_q [SETS];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++) mem_q[s].valid <= 1'b0;
        end else if (wr_en) begin
            mem_q[fl_set] <= wr_entry;
        end
    end

    assign rd_entry = mem_q[rd_set];
    assign fl_entry = mem_q[fl_set];
endmodule

// File: rtl/tlb_ages.sv
module tlb_ages
    import tlb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic fill_en,
    input  set_t fill_set,
    input  way_t fill_way,
    input  logic hit_en,
    input  set_t hit_set,
    input  way_t hit_way,
    output way_t victim
);
    ages_t age_q [SETS];

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (rst || flush)
                age_q[s] <= ages_init();
            else if (fill_en && fill_set == set_t'(s))
                age_q[s] <= ages_touch(age_q[s], fill_way);
            else if (hit_en && hit_set == set_t'(s))
                age_q[s] <= ages_touch(age_q[s], hit_way);
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < WAYS; i++)
            if (age_q[fill_set][i] == way_t'(WAYS - 1)) victim = way_t'(i);
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              lk_en,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [CTRL_W-1:0] lk_ctrl,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [CTRL_W-1:0] fill_ctrl
);
    set_t   lk_set, fl_set;
    tag_t   lk_tag, fl_tag;
    entry_t rd_e [WAYS];
    entry_t fl_e [WAYS];
    entry_t wr_entry;
    logic   fill_go;
    logic   hit_any;
    way_t   hit_way, fill_way, victim;

    assign lk_set  = lk_vpn[SET_BITS-1:0];
    assign lk_tag  = lk_vpn[VPN_W-1:SET_BITS];
    assign fl_set  = fill_vpn[SET_BITS-1:0];
    assign fl_tag  = fill_vpn[VPN_W-1:SET_BITS];
    assign fill_go = fill_en && !flush;
    assign wr_entry = '{valid: 1'b1, tag: fl_tag, ppn: fill_ppn, ctrl: fill_ctrl};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way u_way (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .rd_set   (lk_set),
            .fl_set   (fl_set),
            .wr_en    (fill_go && fill_way == way_t'(w)),
            .wr_entry (wr_entry),
            .rd_entry (rd_e[w]),
            .fl_entry (fl_e[w])
        );
    end

    // lookup side: tag compare and one-hot style merge
    always_comb begin
        hit_any = 1'b0;
        hit_way = '0;
        lk_ppn  = '0;
        lk_ctrl = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (lk_en && rd_e[i].valid && rd_e[i].tag == lk_tag) begin
                hit_any = 1'b1;
                hit_way = way_t'(i);
                lk_ppn  = lk_ppn  | rd_e[i].ppn;
                lk_ctrl = lk_ctrl | rd_e[i].ctrl;
            end
        end
    end
    assign lk_hit = hit_any;

    // fill side: existing match, else lowest empty way, else LRU victim
    always_comb begin
        logic dup, empty;
        way_t dup_w, empty_w;
        dup = 1'b0; empty = 1'b0; dup_w = '0; empty_w = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (fl_e[i].valid && fl_e[i].tag == fl_tag) begin
                dup = 1'b1; dup_w = way_t'(i);
            end
            if (!fl_e[i].valid) begin
                empty = 1'b1; empty_w = way_t'(i);
            end
        end
        if (dup)        fill_way = dup_w;
        else if (empty) fill_way = empty_w;
        else            fill_way = victim;
    end

    tlb_ages u_ages (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .fill_en  (fill_go),
        .fill_set (fl_set),
        .fill_way (fill_way),
        .hit_en   (hit_any),
        .hit_set  (lk_set),
        .hit_way  (hit_way),
        .victim   (victim)
    );
endmodule

// File: rtl/tlb_lru_chk.sv
module tlb_lru_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              lk_en,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              lk_hit,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic [CTRL_W-1:0] lk_ctrl,
    input logic              fill_en,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [PPN_W-1:0]  fill_ppn,
    input logic [CTRL_W-1:0] fill_ctrl
);
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_en |-> (!lk_hit && lk_ppn == '0 && lk_ctrl == '0));

    a_r4_fill_visible: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fill_en && !flush) && lk_en && lk_vpn == $past(fill_vpn))
        |-> (lk_hit && lk_ppn == $past(fill_ppn) && lk_ctrl == $past(fill_ctrl)));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    a_r2_stable_lookup: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fill_en) && !$past(flush) && $past(lk_en) && lk_en
         && lk_vpn == $past(lk_vpn))
        |-> (lk_hit == $past(lk_hit) && lk_ppn == $past(lk_ppn)));
endmodule

bind tlb_lru tlb_lru_chk u_chk (.*);

// File: tb/tlb_lru_test.sv
module tlb_lru_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        lk_en = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic [3:0]  lk_ctrl;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_ctrl = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tlb_lru uut (.*);

    typedef struct packed {
        logic [1:0]  op;   // 0 lookup, 1 fill, 2 flush
        logic [19:0] vpn;
        logic [19:0] ppn;  // fill value or expected value
        logic        hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 20'h00015, 20'h00000, 1'b0, 4'd1},  // R1 empty after reset
        '{2'd1, 20'h00015, 20'h80015, 1'b0, 4'd4},
        '{2'd0, 20'h00015, 20'h80015, 1'b1, 4'd4},  // R4
        '{2'd1, 20'h00025, 20'h80025, 1'b0, 4'd5},
        '{2'd1, 20'h00035, 20'h80035, 1'b0, 4'd5},
        '{2'd1, 20'h00045, 20'h80045, 1'b0, 4'd5},
        '{2'd0, 20'h00015, 20'h80015, 1'b1, 4'd5},  // R5 all four kept
        '{2'd0, 20'h00025, 20'h80025, 1'b1, 4'd5},
        '{2'd0, 20'h00035, 20'h80035, 1'b1, 4'd5},
        '{2'd0, 20'h00045, 20'h80045, 1'b1, 4'd5},
        '{2'd1, 20'h00055, 20'h80055, 1'b0, 4'd6},
        '{2'd0, 20'h00015, 20'h00000, 1'b0, 4'd6},  // R6 LRU evicted
        '{2'd0, 20'h00055, 20'h80055, 1'b1, 4'd6},
        '{2'd0, 20'h00025, 20'h80025, 1'b1, 4'd7},  // R7 touch
        '{2'd1, 20'h00015, 20'h90015, 1'b0, 4'd7},
        '{2'd0, 20'h00035, 20'h00000, 1'b0, 4'd7},
        '{2'd0, 20'h00025, 20'h80025, 1'b1, 4'd7},
        '{2'd1, 20'h00025, 20'h91025, 1'b0, 4'd8},
        '{2'd0, 20'h00025, 20'h91025, 1'b1, 4'd8},  // R8 in place
        '{2'd0, 20'h00045, 20'h80045, 1'b1, 4'd8},
        '{2'd0, 20'h00055, 20'h80055, 1'b1, 4'd8},
        '{2'd0, 20'h00015, 20'h90015, 1'b1, 4'd8},
        '{2'd2, 20'h00000, 20'h00000, 1'b0, 4'd9},
        '{2'd0, 20'h00015, 20'h00000, 1'b0, 4'd9},  // R9
        '{2'd0, 20'h00055, 20'h00000, 1'b0, 4'd9},
        '{2'd1, 20'h10000, 20'h40000, 1'b0, 4'd3},  // R3 sixteen sets
        '{2'd1, 20'h10001, 20'h40001, 1'b0, 4'd3},
        '{2'd1, 20'h10002, 20'h40002, 1'b0, 4'd3},
        '{2'd1, 20'h10003, 20'h40003, 1'b0, 4'd3},
        '{2'd1, 20'h10004, 20'h40004, 1'b0, 4'd3},
        '{2'd1, 20'h10005, 20'h40005, 1'b0, 4'd3},
        '{2'd1, 20'h10006, 20'h40006, 1'b0, 4'd3},
        '{2'd1, 20'h10007, 20'h40007, 1'b0, 4'd3},
        '{2'd1, 20'h10008, 20'h40008, 1'b0, 4'd3},
        '{2'd1, 20'h10009, 20'h40009, 1'b0, 4'd3},
        '{2'd1, 20'h1000A, 20'h4000A, 1'b0, 4'd3},
        '{2'd1, 20'h1000B, 20'h4000B, 1'b0, 4'd3},
        '{2'd1, 20'h1000C, 20'h4000C, 1'b0, 4'd3},
        '{2'd1, 20'h1000D, 20'h4000D, 1'b0, 4'd3},
        '{2'd1, 20'h1000E, 20'h4000E, 1'b0, 4'd3},
        '{2'd1, 20'h1000F, 20'h4000F, 1'b0, 4'd3},
        '{2'd0, 20'h10000, 20'h40000, 1'b1, 4'd3},
        '{2'd0, 20'h10005, 20'h40005, 1'b1, 4'd3},
        '{2'd0, 20'h1000A, 20'h4000A, 1'b1, 4'd3},
        '{2'd0, 20'h1000F, 20'h4000F, 1'b1, 4'd3},
        '{2'd0, 20'h10015, 20'h00000, 1'b0, 4'd2}   // R2 tag mismatch
    };

    function automatic logic [3:0] ctrl_of(logic [19:0] p);
        return p[3:0] ^ 4'h5;
    endfunction

    // called #1 after a negedge with lk inputs already driven
    task automatic chk(input logic exp_hit, input logic [19:0] exp_ppn, input int req);
        logic [3:0]  ec;
        logic [19:0] ep;
        ep = exp_hit ? exp_ppn : 20'h0;
        ec = exp_hit ? ctrl_of(exp_ppn) : 4'h0;
        checks++;
        if (lk_hit !== exp_hit || lk_ppn !== ep || lk_ctrl !== ec) begin
            fails++;
            $display("FAIL R%0d vpn=%h: hit=%b ppn=%h ctrl=%h expected hit=%b ppn=%h ctrl=%h",
                     req, lk_vpn, lk_hit, lk_ppn, lk_ctrl, exp_hit, ep, ec);
        end
    endtask

    task automatic look(input logic [19:0] v, input logic h, input logic [19:0] p, input int req);
        lk_en = 1'b1; lk_vpn = v;
        #1 chk(h, p, req);
        @(negedge clk);
        lk_en = 1'b0;
    endtask

    task automatic put(input logic [19:0] v, input logic [19:0] p);
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_ctrl = ctrl_of(p);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic fill_set9();
        do_flush();
        put(20'h00109, 20'h50109);
        put(20'h00209, 20'h50209);
        put(20'h00309, 20'h50309);
        put(20'h00409, 20'h50409);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: look(VEC[i].vpn, VEC[i].hit, VEC[i].ppn, int'(VEC[i].req));
                2'd1: put(VEC[i].vpn, VEC[i].ppn);
                default: do_flush();
            endcase
        end

        // R2: lk_en low gives no hit even for a resident page
        lk_en = 1'b0; lk_vpn = 20'h10000;
        #1 chk(1'b0, 20'h0, 2);
        @(negedge clk);

        // R10 same set: fill's order update wins over the lookup's
        fill_set9();
        lk_en = 1'b1; lk_vpn = 20'h00209;
        fill_en = 1'b1; fill_vpn = 20'h00509; fill_ppn = 20'h50509; fill_ctrl = ctrl_of(20'h50509);
        #1 chk(1'b1, 20'h50209, 10);
        @(negedge clk);
        lk_en = 1'b0; fill_en = 1'b0;
        put(20'h00609, 20'h50609);
        look(20'h00109, 1'b0, 20'h0, 10);
        look(20'h00209, 1'b0, 20'h0, 10);
        look(20'h00309, 1'b1, 20'h50309, 10);
        look(20'h00609, 1'b1, 20'h50609, 10);

        // R10 different sets: both updates apply
        fill_set9();
        lk_en = 1'b1; lk_vpn = 20'h00109;
        fill_en = 1'b1; fill_vpn = 20'h00701; fill_ppn = 20'h50701; fill_ctrl = ctrl_of(20'h50701);
        #1 chk(1'b1, 20'h50109, 10);
        @(negedge clk);
        lk_en = 1'b0; fill_en = 1'b0;
        put(20'h00509, 20'h50509);
        look(20'h00109, 1'b1, 20'h50109, 10);
        look(20'h00209, 1'b0, 20'h0, 10);
        look(20'h00701, 1'b1, 20'h50701, 10);

        // R7: disabled lookup leaves order, so way of 0x00109 is evicted
        fill_set9();
        lk_en = 1'b0; lk_vpn = 20'h00109;
        @(negedge clk);
        put(20'h00509, 20'h50509);
        look(20'h00109, 1'b0, 20'h0, 7);
        look(20'h00209, 1'b1, 20'h50209, 7);

        // R9: fill in the flush cycle is dropped
        flush = 1'b1;
        fill_en = 1'b1; fill_vpn = 20'h00A0A; fill_ppn = 20'h50A0A; fill_ctrl = ctrl_of(20'h50A0A);
        @(negedge clk);
        flush = 1'b0; fill_en = 1'b0;
        look(20'h00A0A, 1'b0, 20'h0, 9);
        look(20'h00509, 1'b0, 20'h0, 9);

        // R1: reset mid-run empties the buffer
        put(20'h00B0B, 20'h50B0B);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        look(20'h00B0B, 1'b0, 20'h0, 1);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end
endmodule